// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block sits on the controller side of an open-drain two-wire serial bus and returns the bus to a usable state after a transfer was cut short, power dropped or a reset hit mid-transaction. In that situation a target device may still be holding the data line low while it waits for clock edges. On a trigger, the sequencer clocks the bus one pulse at a time, up to nine pulses. At the end of each clock-high phase it looks at the data line. The first time it finds the data line released, it stops clocking and drives a start condition.

Both lines are pulled up outside the block, so every output is a drive-low enable: 1 pulls the line low and 0 releases it. A divider input sets the length of each half clock period in system cycles. After a good recovery the block pulses `done_o` and leaves the clock and data lines held low, ready for the next transfer. If nine pulses go by without the data line releasing, it pulses `fail_o`, releases both lines and returns to idle.

The controller is one state machine. Its states are: ST_IDLE (both lines released), ST_CLK_LO and ST_CLK_HI (the two halves of a recovery pulse), ST_SU_LO (clock low, data released, start setup), ST_SU_HI (clock released, data released), ST_START (clock released, data pulled low), ST_OK (one-cycle done pulse), ST_PARK (both lines held low) and ST_FAIL (one-cycle fail pulse). Its transitions are:
- trigger: ST_IDLE or ST_PARK to ST_CLK_LO
- phase end: ST_CLK_LO to ST_CLK_HI
- data released: ST_CLK_HI to ST_SU_LO
- still stuck: ST_CLK_HI to ST_CLK_LO
- give up: ST_CLK_HI to ST_FAIL
- setup steps: ST_SU_LO to ST_SU_HI to ST_START to ST_OK
- park: ST_OK to ST_PARK
- retire: ST_FAIL to ST_IDLE

Top module: `bus_recovery_seq`

## Requirements
- R1: While reset is held and right after it, both drive-low outputs are 0 and `done_o` and `fail_o` are 0.
- R2: A trigger seen in ST_IDLE or ST_PARK starts recovery. At the first sample after the trigger edge, the clock is driven low and data is released. Every half phase then lasts H+1 system cycles, where H is the `half_period_i` value captured at the trigger.
- R3: The data line is sampled at the last cycle of each clock-high phase. The first high sample ends the clocking, so a target that releases after its K-th released clock edge (K at least 1) gets exactly K recovery pulses. With K=0 it gets one pulse.
- R4: After data is seen high, the block forms a start condition. It holds the clock low with data released for one half phase, then releases the clock for one half phase, then pulls data low while the clock stays released for one half phase, then pulls the clock low.
- R5: `done_o` is high for exactly one cycle. With N recovery pulses it rises (2N+3)(H+1) cycles after the trigger edge. While it is high, and afterwards until the next trigger, the clock and data lines are both driven low.
- R6: If the ninth sample is still low, `fail_o` is high for exactly one cycle, 18(H+1) cycles after the trigger edge. Both lines are released then and afterwards, and no start condition is driven.
- R7: The data drive changes only while the clock is driven low, except for the start condition's data pull, which happens with the clock released.
- R8: A trigger that arrives while a recovery runs, including the cycle in which `done_o` or `fail_o` is high, has no effect on timing, pulse count or final line state.
- R9: A trigger from ST_PARK releases data while the clock stays driven low.
- R10: A single recovery releases the clock at most ten times: nine pulses plus the start condition.

Port order for the table below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trigger_i | input | 1 | Start a recovery attempt |
| half_period_i | input | DIV_W | Half clock phase length minus one, in system cycles |
| sda_in_i | input | 1 | Sampled level of the data line |
| scl_drive_low_o | output | 1 | 1 pulls the clock line low |
| sda_drive_low_o | output | 1 | 1 pulls the data line low |
| done_o | output | 1 | One-cycle pulse: start condition completed |
| fail_o | output | 1 | One-cycle pulse: data never released |

## Verification
Two decisions can land in the same cycle. The first is the ninth-pulse sample: the data line can release on exactly the last allowed pulse, so the give-up decision and the data-released decision are taken on the same phase end. The bench provokes this with a target that releases on the ninth edge and with one that releases on the tenth. The first case must end in a start condition at the success time and the second must end in a fail. The second overlap is a new trigger raised in the very cycle `done_o` or `fail_o` is high. It must leave the parked or idle lines unchanged for several half phases, with no further pulse.

// File: rtl/busrec_pkg.sv
package busrec_pkg;

    typedef enum logic [3:0] {
        ST_IDLE   = 4'd0,
        ST_CLK_LO = 4'd1,
        ST_CLK_HI = 4'd2,
        ST_SU_LO  = 4'd3,
        ST_SU_HI  = 4'd4,
        ST_START  = 4'd5,
        ST_OK     = 4'd6,
        ST_PARK   = 4'd7,
        ST_FAIL   = 4'd8
    } rec_state_t;

endpackage

// File: rtl/busrec_timer.sv
// Half-phase timer: counts 0..limit and flags the terminal count.
module busrec_timer #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIV_W-1:0] limit_in,
    input  logic             run,
    output logic             tick
);

    logic [DIV_W-1:0] limit_q;
    logic [DIV_W-1:0] cnt_q;
    logic             at_end;

    assign at_end = (cnt_q == limit_q);
    assign tick   = run && at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            limit_q <= '0;
            cnt_q   <= '0;
        end else if (load) begin
            limit_q <= limit_in;
            cnt_q   <= '0;
        end else if (run) begin
            if (at_end) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
        end
    end

endmodule

// File: rtl/busrec_pulse_ctr.sv
// Counts finished recovery pulses; flags the last permitted one.
module busrec_pulse_ctr #(
    parameter int MAX_PULSES = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic last
);

    localparam int CNT_W = $clog2(MAX_PULSES + 1);

    logic [CNT_W-1:0] cnt_q;

    assign last = (cnt_q == CNT_W'(MAX_PULSES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/bus_recovery_seq.sv
module bus_recovery_seq
    import busrec_pkg::*;
#(
    parameter int DIV_W      = 16,
    parameter int MAX_PULSES = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trigger_i,
    input  logic [DIV_W-1:0] half_period_i,
    input  logic             sda_in_i,
    output logic             scl_drive_low_o,
    output logic             sda_drive_low_o,
    output logic             done_o,
    output logic             fail_o
);

    rec_state_t state_q;
    rec_state_t state_d;

    logic accept;
    logic timer_run;
    logic tick;
    logic last_pulse;
    logic pulse_done;

    // A new attempt is accepted only while at rest.
    assign accept     = trigger_i && ((state_q == ST_IDLE) || (state_q == ST_PARK));
    assign pulse_done = (state_q == ST_CLK_HI) && tick;
    assign timer_run  = (state_q == ST_CLK_LO) || (state_q == ST_CLK_HI) ||
                        (state_q == ST_SU_LO)  || (state_q == ST_SU_HI)  ||
                        (state_q == ST_START);

    busrec_timer #(
        .DIV_W(DIV_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .limit_in (half_period_i),
        .run      (timer_run),
        .tick     (tick)
    );

    busrec_pulse_ctr #(
        .MAX_PULSES(MAX_PULSES)
    ) u_pulses (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (accept),
        .inc   (pulse_done),
        .last  (last_pulse)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_PARK: begin
                if (accept) state_d = ST_CLK_LO;
            end
            ST_CLK_LO: begin
                if (tick) state_d = ST_CLK_HI;
            end
            ST_CLK_HI: begin
                if (tick) begin
                    if (sda_in_i)        state_d = ST_SU_LO;
                    else if (last_pulse) state_d = ST_FAIL;
                    else                 state_d = ST_CLK_LO;
                end
            end
            ST_SU_LO: begin
                if (tick) state_d = ST_SU_HI;
            end
            ST_SU_HI: begin
                if (tick) state_d = ST_START;
            end
            ST_START: begin
                if (tick) state_d = ST_OK;
            end
            ST_OK:   state_d = ST_PARK;
            ST_FAIL: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode
    always_comb begin
        scl_drive_low_o = 1'b0;
        sda_drive_low_o = 1'b0;
        done_o          = 1'b0;
        fail_o          = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_CLK_LO: scl_drive_low_o = 1'b1;
            ST_CLK_HI: ;
            ST_SU_LO:  scl_drive_low_o = 1'b1;
            ST_SU_HI:  ;
            ST_START:  sda_drive_low_o = 1'b1;
            ST_OK: begin
                scl_drive_low_o = 1'b1;
                sda_drive_low_o = 1'b1;
                done_o          = 1'b1;
            end
            ST_PARK: begin
                scl_drive_low_o = 1'b1;
                sda_drive_low_o = 1'b1;
            end
            ST_FAIL: fail_o = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/busrec_chk.sv
module busrec_chk #(
    parameter int MAX_PULSES = 9
) (
    input logic clk,
    input logic rst_n,
    input logic scl_drive_low_o,
    input logic sda_drive_low_o,
    input logic done_o,
    input logic fail_o
);

    logic [7:0] rel_cnt_q;
    logic       scl_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rel_cnt_q  <= '0;
            scl_prev_q <= 1'b0;
        end else begin
            scl_prev_q <= scl_drive_low_o;
            if (done_o || fail_o) begin
                rel_cnt_q <= '0;
            end else if (scl_prev_q && !scl_drive_low_o && rel_cnt_q != 8'hFF) begin
                rel_cnt_q <= rel_cnt_q + 8'd1;
            end
        end
    end

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!done_o && !fail_o && !scl_drive_low_o && !sda_drive_low_o);
        end
    end

    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R5
    done_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (scl_drive_low_o && sda_drive_low_o && !fail_o));

    // R6
    fail_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |=> (!fail_o && !scl_drive_low_o && !sda_drive_low_o));

    // R7
    sda_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_drive_low_o) |-> !scl_drive_low_o);

    // R7
    sda_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_drive_low_o) |-> scl_drive_low_o);

    // R10
    pulse_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_cnt_q <= 8'(MAX_PULSES + 1));

endmodule

bind bus_recovery_seq busrec_chk #(
    .MAX_PULSES(MAX_PULSES)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .scl_drive_low_o (scl_drive_low_o),
    .sda_drive_low_o (sda_drive_low_o),
    .done_o          (done_o),
    .fail_o          (fail_o)
);

// File: tb/bus_recovery_seq_tb.sv
module bus_recovery_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trigger_i = 1'b0;
    logic [15:0] half_period_i = '0;
    logic        sda_in_i;
    logic        scl_drive_low_o;
    logic        sda_drive_low_o;
    logic        done_o;
    logic        fail_o;

    int tests  = 0;
    int fails  = 0;
    int rel_seen = 0;
    int k_release = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    // Target model: holds data low until it has seen k_release clock releases.
    assign sda_in_i = !sda_drive_low_o && (rel_seen >= k_release);

    bus_recovery_seq u_dut (
        .clk             (clk),
        .rst_n           (rst_n),
        .trigger_i       (trigger_i),
        .half_period_i   (half_period_i),
        .sda_in_i        (sda_in_i),
        .scl_drive_low_o (scl_drive_low_o),
        .sda_drive_low_o (sda_drive_low_o),
        .done_o          (done_o),
        .fail_o          (fail_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_pulses(input int k);
        return (k < 1) ? 1 : k;
    endfunction

    function automatic int exp_cycles(input int h, input int k);
        if (k <= 9) return (2 * exp_pulses(k) + 3) * (h + 1);
        return 18 * (h + 1);
    endfunction

    task automatic run_one(input int h, input int k, input int inj, input bit trig_end);
        int cyc;
        int rises;
        int bad7;
        bit pscl;
        bit psda;
        bit ok_exp;
        ok_exp        = (k <= 9);
        k_release     = k;
        rel_seen      = 0;
        half_period_i = 16'(h);
        cyc = 0; rises = 0; bad7 = 0;
        @(negedge clk);
        trigger_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        trigger_i = 1'b0;
        // R2 / R9: clock low, data released right after the trigger edge
        check(scl_drive_low_o && !sda_drive_low_o, "R2 first phase", {scl_drive_low_o, sda_drive_low_o}, 2);
        pscl = scl_drive_low_o;
        psda = sda_drive_low_o;
        while (!(done_o || fail_o) && cyc < 4000) begin
            trigger_i = (inj > 0 && cyc == inj);
            @(posedge clk);
            cyc++;
            @(negedge clk);
            if (pscl && !scl_drive_low_o) rel_seen++;
            if (sda_drive_low_o != psda) begin
                if (sda_drive_low_o && scl_drive_low_o) bad7++;
                if (!sda_drive_low_o && !scl_drive_low_o) bad7++;
                if (sda_drive_low_o) rises++;
            end
            pscl = scl_drive_low_o;
            psda = sda_drive_low_o;
        end
        trigger_i = 1'b0;
        check(cyc == exp_cycles(h, k), ok_exp ? "R5 done time" : "R6 fail time", cyc, exp_cycles(h, k));
        check(done_o == ok_exp && fail_o == !ok_exp, "R3 outcome", {done_o, fail_o}, ok_exp ? 2 : 1);
        check(rel_seen == (ok_exp ? exp_pulses(k) + 1 : 9), "R3 R10 clock releases", rel_seen,
              ok_exp ? exp_pulses(k) + 1 : 9);
        check(rises == (ok_exp ? 1 : 0), "R4 start data pull", rises, ok_exp ? 1 : 0);
        check(bad7 == 0, "R7 data change with clock", bad7, 0);
        if (ok_exp)
            check(scl_drive_low_o && sda_drive_low_o, "R5 lines at done", {scl_drive_low_o, sda_drive_low_o}, 3);
        else
            check(!scl_drive_low_o && !sda_drive_low_o, "R6 lines at fail", {scl_drive_low_o, sda_drive_low_o}, 0);
        if (trig_end) trigger_i = 1'b1;  // R8: trigger in the done/fail cycle
        @(posedge clk);
        @(negedge clk);
        trigger_i = 1'b0;
        for (int i = 0; i < h + 3; i++) begin
            @(negedge clk);
            if (done_o || fail_o || scl_drive_low_o != ok_exp || sda_drive_low_o != ok_exp) bad7 += 100;
        end
        check(bad7 == 0, "R8 rest state held", bad7, 0);
    endtask

    initial begin
        int h;
        int k;
        int inj;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1
        check(!scl_drive_low_o && !sda_drive_low_o && !done_o && !fail_o, "R1 reset",
              {scl_drive_low_o, sda_drive_low_o, done_o, fail_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!scl_drive_low_o && !sda_drive_low_o && !done_o && !fail_o, "R1 after reset",
              {scl_drive_low_o, sda_drive_low_o, done_o, fail_o}, 0);
        // Directed corners
        run_one(0, 9, 0, 1'b0);   // R3 release on ninth pulse: success
        run_one(0, 10, 0, 1'b1);  // R6 never releases in time, trigger on fail cycle
        run_one(2, 0, 0, 1'b1);   // R3 already released, trigger on done cycle
        run_one(1, 3, 0, 1'b0);   // R9 from parked state
        run_one(3, 5, 7, 1'b0);   // R8 trigger mid-run
        run_one(0, 1, 2, 1'b0);
        // Random mix
        for (int r = 0; r < 30; r++) begin
            h = int'($urandom_range(0, 7));
            k = int'($urandom_range(0, 12));
            inj = int'($urandom_range(0, 3)) == 0 ? 0 : int'($urandom_range(1, (h + 1) * 2));
            run_one(h, k, inj, $urandom_range(0, 1) == 1);
        end
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #1500000;
        if (!finished) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule